// File: doc/BRIEF.md
# Isochronous Pipe Interval Controller

This block runs one isochronous pipe that sits over a ring of packet buffers (two by default, used alternately so one fills while the other drains). Each token addressed to the pipe gets a response. The response depends only on whether the buffer the pipe currently points at is ready.

- An IN pipe sends the buffered packet, or an empty packet with an underrun indication.
- An OUT pipe accepts the packet, or drops it with an overrun indication and a not-ready (NRDY) cause.

A successful transfer steps the pointer to the next buffer and strobes a swap. Tokens that arrive before the expected frame are answered by the same rule.

The block also watches the frame cadence. An interval setting N gives a window of 2^N frames. When the pipe is armed and a whole window closes with no token, an interval error is raised. On an IN pipe this error strobes a buffer flush. On an OUT pipe it raises an NRDY indication instead. Arming depends on N:

- When N is zero, monitoring starts in the frame after the first frame start seen once the pipe is enabled.
- For any other N, monitoring waits for the first normal transfer.

Error causes are kept in sticky flags that software clears by writing ones.

Top module: `iso_pipe_ivl`

## Requirements
- R1: An IN token on an IN pipe whose current buffer is ready gives response code 1 (data) naming that buffer, strobes `swap_o`, and moves the pointer to the next buffer (buffer 0 after the last).
- R2: An IN token with the current buffer not ready gives code 2 (empty packet), pulses `unr_o`, sets flag bit 0 (underrun), and leaves the pointer unchanged.
- R3: An OUT token on an OUT pipe whose current buffer is ready gives code 1 (accept), strobes `swap_o`, and moves the pointer.
- R4: An OUT token with the current buffer not ready gives code 3 (discard) and pulses `ovr_o`. It sets flag bit 1 (overrun) and flag bit 2 (NRDY).
- R5: No response is produced for a token whose direction differs from the pipe direction, or for any token while the pipe is disabled. Disabling the pipe returns the pointer to buffer 0.
- R6: With N = 0, the first frame start after enable only arms the monitor. Each later frame start raises an interval error if no token was seen in the frame just ended.
- R7: With N ≠ 0, no interval error occurs before the first normal transfer. After it, frames are grouped into windows of 2^N. A window with no token ends in an interval error at the frame start that closes it.
- R8: An interval error on an IN pipe gives a one-cycle `flush_o` pulse at the closing frame start, and sets flag bit 3 (interval error).
- R9: An interval error on an OUT pipe gives no flush. It sets flag bits 2 and 3 but not bit 1, so overrun stays distinguishable.
- R10: Flags are sticky and reset to zero. A one on `clr_i[k]` clears bit k, and a set event in the same cycle wins over the clear.
- R11: Responses and pulses are registered. They appear in the cycle after the token or frame start, last one cycle, and `resp_o` is 0 whenever `resp_vld_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pipe_en_i | input | 1 | Pipe enabled |
| pipe_dir_in_i | input | 1 | Pipe direction, 1 = IN |
| interval_i | input | IVW | Interval exponent N, window of 2^N frames |
| sof_i | input | 1 | Frame start pulse |
| tok_i | input | 1 | Token pulse |
| tok_dir_in_i | input | 1 | Token direction, 1 = IN |
| buf_rdy_i | input | NBUF | Per-buffer ready (IN: loaded, OUT: free) |
| clr_i | input | 4 | Write-one-to-clear for the flags |
| resp_vld_o | output | 1 | Response valid |
| resp_o | output | 2 | 0 none, 1 data, 2 empty packet, 3 discard |
| resp_buf_o | output | PTR_W | Buffer used by the response |
| swap_o | output | 1 | Buffer consumed, pointer moved |
| flush_o | output | 1 | IN buffer flush strobe |
| unr_o | output | 1 | Underrun pulse |
| ovr_o | output | 1 | Overrun pulse |
| flags_o | output | 4 | Sticky: 0 underrun, 1 overrun, 2 NRDY, 3 interval error |

## Verification
The hardest case to reach is the window boundary for N ≠ 0. The monitor must stay silent while it is unarmed, through frames with no traffic. Once armed, the window that holds the arming transfer must pass. Only the following empty window may fail.

The stimulus re-enables the pipe with N = 1 and issues three idle frame starts to show that nothing fires. It then makes one ready transfer and steps four frame starts, expecting a flush on the fourth only. A separate OUT run with N = 0 shows that the same timeout lands in the NRDY and interval flags, with no flush and no overrun.

// File: rtl/iso_pipe_pkg.sv
package iso_pipe_pkg;
  typedef enum logic [1:0] {
    RESP_NONE = 2'd0,
    RESP_DATA = 2'd1,
    RESP_ZLP  = 2'd2,
    RESP_DISC = 2'd3
  } resp_e;

  localparam int unsigned FLG_UNR  = 0;
  localparam int unsigned FLG_OVR  = 1;
  localparam int unsigned FLG_NRDY = 2;
  localparam int unsigned FLG_IVL  = 3;
  localparam int unsigned NFLG     = 4;
endpackage

// File: rtl/iso_resp_sel.sv
module iso_resp_sel
  import iso_pipe_pkg::*;
#(
  parameter  int unsigned NBUF  = 2,
  localparam int unsigned PTR_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             dir_in_i,
  input  logic             tok_i,
  input  logic             tok_dir_in_i,
  input  logic [NBUF-1:0]  buf_rdy_i,
  output logic             hit_o,
  output logic             normal_o,
  output logic             resp_vld_o,
  output resp_e            resp_o,
  output logic [PTR_W-1:0] resp_buf_o,
  output logic             swap_o,
  output logic             unr_o,
  output logic             ovr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic             hit, rdy;
  resp_e            resp_d;

  assign hit      = en_i && tok_i && (tok_dir_in_i == dir_in_i);
  assign rdy      = buf_rdy_i[ptr_q];
  assign hit_o    = hit;
  assign normal_o = hit && rdy;
  assign ptr_nxt  = (ptr_q == PTR_W'(NBUF - 1)) ? '0 : ptr_q + 1'b1;

  always_comb begin
    if (!hit)          resp_d = RESP_NONE;
    else if (rdy)      resp_d = RESP_DATA;
    else if (dir_in_i) resp_d = RESP_ZLP;
    else               resp_d = RESP_DISC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      resp_vld_o <= 1'b0;
      resp_o     <= RESP_NONE;
      resp_buf_o <= '0;
      swap_o     <= 1'b0;
      unr_o      <= 1'b0;
      ovr_o      <= 1'b0;
    end else begin
      resp_vld_o <= hit;
      resp_o     <= resp_d;
      resp_buf_o <= ptr_q;
      swap_o     <= hit && rdy;
      unr_o      <= hit && !rdy && dir_in_i;
      ovr_o      <= hit && !rdy && !dir_in_i;
      if (!en_i)          ptr_q <= '0;
      else if (hit && rdy) ptr_q <= ptr_nxt;
    end
  end
endmodule

// File: rtl/iso_ivl_timer.sv
module iso_ivl_timer #(
  parameter int unsigned IVW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           dir_in_i,
  input  logic [IVW-1:0] interval_i,
  input  logic           sof_i,
  input  logic           hit_i,
  input  logic           normal_i,
  output logic           flush_o,
  output logic           oerr_o
);
  localparam int unsigned CNT_W = (1 << IVW) - 1;

  logic             armed_q, seen_q;
  logic [CNT_W-1:0] cnt_q, lim;

  // last frame index of a 2^N window
  assign lim = CNT_W'((32'd1 << interval_i) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
      cnt_q   <= '0;
      flush_o <= 1'b0;
      oerr_o  <= 1'b0;
    end else begin
      flush_o <= 1'b0;
      oerr_o  <= 1'b0;
      if (!en_i) begin
        armed_q <= 1'b0;
        seen_q  <= 1'b0;
        cnt_q   <= '0;
      end else if (!armed_q) begin
        if (interval_i == '0) begin
          if (sof_i) begin
            armed_q <= 1'b1;
            seen_q  <= 1'b0;
            cnt_q   <= '0;
          end
        end else if (normal_i) begin
          armed_q <= 1'b1;
          seen_q  <= 1'b1;
          cnt_q   <= '0;
        end
      end else if (sof_i) begin
        if (cnt_q >= lim) begin
          cnt_q  <= '0;
          seen_q <= hit_i;
          if (!seen_q) begin
            flush_o <= dir_in_i;
            oerr_o  <= !dir_in_i;
          end
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          seen_q <= seen_q || hit_i;
        end
      end else if (hit_i) begin
        seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/iso_flag_bank.sv
module iso_flag_bank #(
  parameter int unsigned NF = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] q_o
);
  for (genvar k = 0; k < NF; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[k] <= 1'b0;
      else         q_o[k] <= set_i[k] || (q_o[k] && !clr_i[k]);
    end
  end
endmodule

// File: rtl/iso_pipe_ivl.sv
module iso_pipe_ivl
  import iso_pipe_pkg::*;
#(
  parameter  int unsigned NBUF  = 2,
  parameter  int unsigned IVW   = 4,
  localparam int unsigned PTR_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pipe_en_i,
  input  logic             pipe_dir_in_i,
  input  logic [IVW-1:0]   interval_i,
  input  logic             sof_i,
  input  logic             tok_i,
  input  logic             tok_dir_in_i,
  input  logic [NBUF-1:0]  buf_rdy_i,
  input  logic [NFLG-1:0]  clr_i,
  output logic             resp_vld_o,
  output logic [1:0]       resp_o,
  output logic [PTR_W-1:0] resp_buf_o,
  output logic             swap_o,
  output logic             flush_o,
  output logic             unr_o,
  output logic             ovr_o,
  output logic [NFLG-1:0]  flags_o
);
  logic            hit, normal, oerr;
  resp_e           resp;
  logic [NFLG-1:0] flg_set;

  iso_resp_sel #(.NBUF(NBUF)) u_resp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (pipe_en_i),
    .dir_in_i     (pipe_dir_in_i),
    .tok_i        (tok_i),
    .tok_dir_in_i (tok_dir_in_i),
    .buf_rdy_i    (buf_rdy_i),
    .hit_o        (hit),
    .normal_o     (normal),
    .resp_vld_o   (resp_vld_o),
    .resp_o       (resp),
    .resp_buf_o   (resp_buf_o),
    .swap_o       (swap_o),
    .unr_o        (unr_o),
    .ovr_o        (ovr_o)
  );

  iso_ivl_timer #(.IVW(IVW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (pipe_en_i),
    .dir_in_i   (pipe_dir_in_i),
    .interval_i (interval_i),
    .sof_i      (sof_i),
    .hit_i      (hit),
    .normal_i   (normal),
    .flush_o    (flush_o),
    .oerr_o     (oerr)
  );

  always_comb begin
    flg_set           = '0;
    flg_set[FLG_UNR]  = unr_o;
    flg_set[FLG_OVR]  = ovr_o;
    flg_set[FLG_NRDY] = ovr_o || oerr;
    flg_set[FLG_IVL]  = flush_o || oerr;
  end

  iso_flag_bank #(.NF(NFLG)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flg_set),
    .clr_i  (clr_i),
    .q_o    (flags_o)
  );

  assign resp_o = resp;
endmodule

// File: rtl/iso_pipe_ivl_chk.sv
module iso_pipe_ivl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pipe_en_i,
  input logic       pipe_dir_in_i,
  input logic       resp_vld_o,
  input logic [1:0] resp_o,
  input logic       swap_o,
  input logic       flush_o,
  input logic       unr_o,
  input logic       ovr_o,
  input logic [3:0] flags_o
);
  a_r1_swap_on_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_o |-> (resp_vld_o && resp_o == 2'd1));
  a_r2_zlp_underrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_vld_o && resp_o == 2'd2) |-> unr_o);
  a_r2_underrun_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unr_o |=> flags_o[0]);
  a_r4_overrun_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> (flags_o[1] && flags_o[2]));
  a_r5_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(pipe_en_i) |-> !resp_vld_o);
  a_r8_flush_in_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> $past(pipe_dir_in_i));
  a_r8_flush_latched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> flags_o[3]);
  a_r11_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_vld_o |-> (resp_o == 2'd0));
endmodule

bind iso_pipe_ivl iso_pipe_ivl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .pipe_en_i     (pipe_en_i),
  .pipe_dir_in_i (pipe_dir_in_i),
  .resp_vld_o    (resp_vld_o),
  .resp_o        (resp_o),
  .swap_o        (swap_o),
  .flush_o       (flush_o),
  .unr_o         (unr_o),
  .ovr_o         (ovr_o),
  .flags_o       (flags_o)
);

// File: tb/sim_iso_pipe_ivl.sv
module sim_iso_pipe_ivl;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       pipe_en_i, pipe_dir_in_i, sof_i, tok_i, tok_dir_in_i;
  logic [3:0] interval_i;
  logic [1:0] buf_rdy_i;
  logic [3:0] clr_i;
  logic       resp_vld_o, swap_o, flush_o, unr_o, ovr_o;
  logic [1:0] resp_o;
  logic [0:0] resp_buf_o;
  logic [3:0] flags_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk_i = ~clk_i;

  iso_pipe_ivl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .pipe_en_i(pipe_en_i), .pipe_dir_in_i(pipe_dir_in_i),
    .interval_i(interval_i), .sof_i(sof_i), .tok_i(tok_i), .tok_dir_in_i(tok_dir_in_i),
    .buf_rdy_i(buf_rdy_i), .clr_i(clr_i), .resp_vld_o(resp_vld_o), .resp_o(resp_o),
    .resp_buf_o(resp_buf_o), .swap_o(swap_o), .flush_o(flush_o), .unr_o(unr_o),
    .ovr_o(ovr_o), .flags_o(flags_o)
  );

  // [9] pipe IN, [8] token IN, [7:6] ready, [5] vld, [4:3] code, [2] buf, [1] unr, [0] ovr
  localparam logic [9:0] VEC [8] = '{
    10'b1_1_01_1_01_0_0_0,
    10'b1_1_01_1_10_1_1_0,
    10'b1_1_10_1_01_1_0_0,
    10'b1_0_11_0_00_0_0_0,
    10'b0_0_00_1_11_0_0_1,
    10'b0_0_01_1_01_0_0_0,
    10'b0_1_11_0_00_0_0_0,
    10'b0_0_10_1_01_1_0_0
  };
  string req_tbl [8] = '{"R1", "R2", "R1", "R5", "R4", "R3", "R5", "R3"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic frame();
    sof_i = 1'b1;
    @(negedge clk_i);
    sof_i = 1'b0;
  endtask

  task automatic token(input logic tdir, input logic [1:0] rdy);
    tok_dir_in_i = tdir;
    buf_rdy_i    = rdy;
    tok_i        = 1'b1;
    @(negedge clk_i);
    tok_i        = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; pipe_en_i = 1'b0; pipe_dir_in_i = 1'b1; interval_i = 4'd4;
    sof_i = 1'b0; tok_i = 1'b0; tok_dir_in_i = 1'b1; buf_rdy_i = 2'b00; clr_i = '0;
    repeat (3) tick();
    chk("R11 reset vld", {31'd0, resp_vld_o}, 32'd0);
    chk("R10 reset flags", {28'd0, flags_o}, 32'd0);
    chk("R8 reset flush", {31'd0, flush_o}, 32'd0);
    rst_ni = 1'b1;
    tick();
    pipe_en_i = 1'b1;

    for (int i = 0; i < 8; i++) begin
      pipe_dir_in_i = VEC[i][9];
      token(VEC[i][8], VEC[i][7:6]);
      chk({req_tbl[i], " vld"}, {31'd0, resp_vld_o}, {31'd0, VEC[i][5]});
      chk({req_tbl[i], " code"}, {30'd0, resp_o}, {30'd0, VEC[i][4:3]});
      if (VEC[i][5]) chk({req_tbl[i], " buf"}, {31'd0, resp_buf_o}, {31'd0, VEC[i][2]});
      chk({req_tbl[i], " swap"}, {31'd0, swap_o}, {31'd0, (VEC[i][4:3] == 2'd1)});
      chk({req_tbl[i], " unr"}, {31'd0, unr_o}, {31'd0, VEC[i][1]});
      chk({req_tbl[i], " ovr"}, {31'd0, ovr_o}, {31'd0, VEC[i][0]});
      tick();
      chk("R11 pulses one cycle", {30'd0, unr_o, ovr_o}, 32'd0);
    end

    chk("R10 flags after table", {28'd0, flags_o}, 32'h7);
    clr_i = 4'b0011; tick(); clr_i = '0; tick();
    chk("R10 partial clear", {28'd0, flags_o}, 32'h4);
    clr_i = 4'b0100; tick(); clr_i = '0; tick();
    chk("R10 full clear", {28'd0, flags_o}, 32'h0);

    // set wins over clear in the same cycle
    pipe_dir_in_i = 1'b1;
    token(1'b1, 2'b00);
    chk("R2 underrun pulse", {31'd0, unr_o}, 32'd1);
    clr_i = 4'b0001; tick(); clr_i = '0;
    chk("R10 set beats clear", {31'd0, flags_o[0]}, 32'd1);
    clr_i = 4'hF; tick(); clr_i = '0; tick();

    // disable: silence and pointer back to buffer 0
    token(1'b1, 2'b01);
    chk("R1 advance to buf1", {31'd0, resp_buf_o}, 32'd0);
    pipe_en_i = 1'b0; tick();
    token(1'b1, 2'b11);
    chk("R5 disabled no resp", {31'd0, resp_vld_o}, 32'd0);
    pipe_en_i = 1'b1; tick();
    token(1'b1, 2'b11);
    chk("R5 pointer reset", {31'd0, resp_buf_o}, 32'd0);

    // N = 0 on IN pipe
    pipe_en_i = 1'b0; interval_i = 4'd0; tick();
    pipe_en_i = 1'b1; tick();
    frame();
    chk("R6 arming frame quiet", {31'd0, flush_o}, 32'd0);
    tick();
    frame();
    chk("R8 flush on empty frame", {31'd0, flush_o}, 32'd1);
    tick();
    chk("R8 flush one cycle", {31'd0, flush_o}, 32'd0);
    chk("R8 interval flag", {31'd0, flags_o[3]}, 32'd1);
    token(1'b1, 2'b00);
    tick();
    frame();
    chk("R6 token keeps quiet", {31'd0, flush_o}, 32'd0);
    tick();
    frame();
    chk("R6 next empty frame", {31'd0, flush_o}, 32'd1);
    clr_i = 4'hF; tick(); clr_i = '0; tick();

    // N = 1: unarmed until a normal transfer
    pipe_en_i = 1'b0; interval_i = 4'd1; tick();
    pipe_en_i = 1'b1; tick();
    for (int f = 0; f < 3; f++) begin
      frame();
      chk("R7 unarmed quiet", {31'd0, flush_o}, 32'd0);
      tick();
    end
    token(1'b1, 2'b11);
    for (int f = 0; f < 3; f++) begin
      frame();
      chk("R7 window pass", {31'd0, flush_o}, 32'd0);
      tick();
    end
    frame();
    chk("R7 empty window", {31'd0, flush_o}, 32'd1);
    clr_i = 4'hF; tick(); clr_i = '0; tick();

    // OUT interval error
    pipe_en_i = 1'b0; pipe_dir_in_i = 1'b0; interval_i = 4'd0; tick();
    pipe_en_i = 1'b1; tick();
    frame();
    tick();
    frame();
    chk("R9 no flush on OUT", {31'd0, flush_o}, 32'd0);
    tick();
    chk("R9 flags nrdy+ivl", {28'd0, flags_o}, 32'hC);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule